// File: doc/BRIEF.md
# Early-Wakeup Operand-Capturing Issue Queue

This block buffers up to 16 renamed instructions between dispatch and execution. Each slot records the function-unit class, an opcode, a destination tag and a literal. For each register source it holds either the operand value or, while that value is still being produced, the physical register tag it waits for. Every cycle the queue sends at most one instruction to each of three function-unit classes (integer, multiply, divide). Among the ready candidates for a class, the oldest by dispatch order is chosen.

Four result buses feed the queue at the same time. Each bus announces a producer's tag one cycle before it drives the matching value. A waiting source that sees its tag becomes ready at the next clock edge. In that next cycle the instruction may already issue, and its operand is routed straight from the data bus that now carries the value. This lets a consumer run back to back with its producer. The value is also written into the slot, so a later issue still presents it. A flush empties the queue in one cycle.

Top module: `early_wake_iq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises with no dispatch, every iss_valid_o bit is 0 and disp_ready_o is 1.
- R2: disp_ready_o is 0 exactly when all 16 slots are occupied and none of them issues in the current cycle. A slot that issues can take the dispatch of that same cycle. A dispatch is accepted when disp_valid_i and disp_ready_o are 1 and flush_i is 0.
- R3: A source with disp_src_used_i[s]=0 or disp_src_rdy_i[s]=1 never waits. An instruction whose sources are all ready can issue from the cycle after its dispatch.
- R4: If a waiting source's tag equals bc_tag_i[k] with bc_tag_vld_i[k]=1 in cycle t, the instruction can issue in cycle t+1. Its operand for that source is then bc_data_i[k] of cycle t+1.
- R5: The value on bc_data_i[k] in cycle t+1 is kept in the slot and presented on any later issue of that instruction.
- R6: A source that is dispatched not ready in a cycle where its tag is broadcast is woken exactly as a source already in the queue.
- R7: When several buses carry a source's tag in the same cycle, the lowest-numbered bus supplies its value.
- R8: Classes are encoded 0 = integer, 1 = multiply, 2 = divide, and port index c serves class c. iss_valid_o[c] is 1 only when fu_ready_i[c] is 1. When it is 1, it selects the oldest ready instruction of class c by dispatch order.
- R9: An issued instruction leaves the queue and is never issued again. Instructions that are not selected stay in the queue.
- R10: While flush_i is 1, no iss_valid_o bit is set and dispatch is ignored. From the next cycle on, the queue is empty.
- R11: iss_op_o, iss_dst_o and iss_lit_o of port c carry the opcode, destination tag and literal that were dispatched with the selected instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all queued instructions |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | A slot is free this cycle |
| disp_cls_i | input | 2 | Function-unit class of the dispatched instruction |
| disp_op_i | input | 6 | Opcode |
| disp_dst_i | input | 5 | Destination physical tag |
| disp_lit_i | input | 32 | Literal operand |
| disp_src_used_i | input | 2 | Source s is a register operand |
| disp_src_rdy_i | input | 2 | Source s value is already valid |
| disp_src_tag_i | input | 2x5 | Physical tag per source |
| disp_src_val_i | input | 2x32 | Value per source (used when ready) |
| bc_tag_vld_i | input | 4 | Tag valid per broadcast bus |
| bc_tag_i | input | 4x5 | Early tag per bus |
| bc_data_i | input | 4x32 | Value per bus, one cycle after its tag |
| fu_ready_i | input | 3 | Function unit of class c can accept |
| iss_valid_o | output | 3 | Instruction issued to class c |
| iss_op_o | output | 3x6 | Opcode per port |
| iss_dst_o | output | 3x5 | Destination tag per port |
| iss_lit_o | output | 3x32 | Literal per port |
| iss_src_o | output | 3x2x32 | Source values per port |

## Verification
The hardest states to reach from the ports involve timing between the buses and the queue. One is a wakeup whose tag arrives in the same cycle as the dispatch. Another is two buses announcing the same tag, where the value must come from the correct bus one cycle later. A third is a full queue that frees a slot and refills it in the same cycle. Directed sequences set up each of these and hold fu_ready_i low where needed, so that woken instructions also issue later from their stored values. A long random phase then uses a small tag range and dense broadcasts so these interactions collide often. A behavioural model checks every cycle.

// File: rtl/ewiq_pkg.sv
package ewiq_pkg;
  localparam int unsigned EWIQ_DEPTH     = 16;
  localparam int unsigned EWIQ_TAG_W     = 5;
  localparam int unsigned EWIQ_DATA_W    = 32;
  localparam int unsigned EWIQ_OP_W      = 6;
  localparam int unsigned EWIQ_NUM_SRC   = 2;
  localparam int unsigned EWIQ_NUM_BCAST = 4;
  localparam int unsigned EWIQ_NUM_FU    = 3;

  typedef enum logic [1:0] {
    FU_INT = 2'd0,
    FU_MUL = 2'd1,
    FU_DIV = 2'd2
  } fu_cls_e;
endpackage

// File: rtl/ewiq_alloc.sv
module ewiq_alloc #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] oh_o,
  output logic         any_o
);
  // lowest free slot
  assign oh_o  = free_i & (~free_i + N'(1));
  assign any_o = |free_i;
endmodule

// File: rtl/ewiq_slot.sv
module ewiq_slot #(
  parameter int unsigned TAG_W     = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OP_W      = 6,
  parameter int unsigned NUM_SRC   = 2,
  parameter int unsigned NUM_BCAST = 4,
  parameter int unsigned CLS_W     = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 flush_i,
  input  logic                                 wr_i,
  input  logic                                 iss_i,
  input  logic [CLS_W-1:0]                     cls_i,
  input  logic [OP_W-1:0]                      op_i,
  input  logic [TAG_W-1:0]                     dst_i,
  input  logic [DATA_W-1:0]                    lit_i,
  input  logic [NUM_SRC-1:0]                   src_used_i,
  input  logic [NUM_SRC-1:0]                   src_rdy_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]        src_tag_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]       src_val_i,
  input  logic [NUM_BCAST-1:0]                 bc_vld_i,
  input  logic [NUM_BCAST-1:0][TAG_W-1:0]      bc_tag_i,
  input  logic [NUM_BCAST-1:0][DATA_W-1:0]     bc_data_i,
  output logic                                 vld_o,
  output logic                                 req_o,
  output logic [CLS_W-1:0]                     cls_o,
  output logic [OP_W-1:0]                      op_o,
  output logic [TAG_W-1:0]                     dst_o,
  output logic [DATA_W-1:0]                    lit_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0]       src_val_o
);
  localparam int unsigned BUS_W = (NUM_BCAST > 1) ? $clog2(NUM_BCAST) : 1;

  logic               vld_q;
  logic [NUM_SRC-1:0] src_rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= 1'b0;
    else if (flush_i) vld_q <= 1'b0;
    else if (wr_i)    vld_q <= 1'b1;
    else if (iss_i)   vld_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_o <= '0;
      op_o  <= '0;
      dst_o <= '0;
      lit_o <= '0;
    end else if (wr_i) begin
      cls_o <= cls_i;
      op_o  <= op_i;
      dst_o <= dst_i;
      lit_o <= lit_i;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic                 rdy_q, pend_q;
    logic [BUS_W-1:0]     bus_q;
    logic [TAG_W-1:0]     tag_q;
    logic [DATA_W-1:0]    val_q;
    logic [TAG_W-1:0]     cmp_tag;
    logic                 waiting, hit;
    logic [NUM_BCAST-1:0] hit_vec;
    logic [BUS_W-1:0]     hit_bus;

    assign cmp_tag = wr_i ? src_tag_i[s] : tag_q;
    assign waiting = wr_i ? (src_used_i[s] & ~src_rdy_i[s]) : (vld_q & ~rdy_q);

    for (genvar k = 0; k < NUM_BCAST; k++) begin : g_cmp
      assign hit_vec[k] = bc_vld_i[k] & (bc_tag_i[k] == cmp_tag);
    end

    assign hit = waiting & (|hit_vec);

    always_comb begin
      hit_bus = '0;
      for (int k = NUM_BCAST - 1; k >= 0; k--) begin
        if (hit_vec[k]) hit_bus = BUS_W'(k);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_q  <= 1'b0;
        pend_q <= 1'b0;
        bus_q  <= '0;
        tag_q  <= '0;
        val_q  <= '0;
      end else if (wr_i) begin
        rdy_q  <= ~src_used_i[s] | src_rdy_i[s] | hit;
        pend_q <= hit;
        bus_q  <= hit_bus;
        tag_q  <= src_tag_i[s];
        val_q  <= src_val_i[s];
      end else if (pend_q) begin
        // value follows its tag by one cycle
        val_q  <= bc_data_i[bus_q];
        pend_q <= 1'b0;
      end else if (hit) begin
        rdy_q  <= 1'b1;
        pend_q <= 1'b1;
        bus_q  <= hit_bus;
      end
    end

    assign src_rdy[s]   = rdy_q;
    assign src_val_o[s] = pend_q ? bc_data_i[bus_q] : val_q;
  end

  assign vld_o = vld_q;
  assign req_o = vld_q & (&src_rdy);
endmodule

// File: rtl/ewiq_age_sel.sv
module ewiq_age_sel #(
  parameter int unsigned N      = 16,
  parameter int unsigned NUM_FU = 3,
  parameter int unsigned CLS_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N-1:0]                  alloc_i,
  input  logic [N-1:0]                  vld_i,
  input  logic [N-1:0]                  req_i,
  input  logic [N-1:0][CLS_W-1:0]       cls_i,
  input  logic [NUM_FU-1:0]             go_i,
  output logic [NUM_FU-1:0][N-1:0]      gnt_o
);
  // older_q[i][j]: slot i was dispatched before slot j
  logic [N-1:0][N-1:0]      older_q;
  logic [N-1:0][N-1:0]      older_col;
  logic [NUM_FU-1:0][N-1:0] cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_i[j])      older_q[i][j] <= vld_i[i] & (i != j);
          else if (alloc_i[i]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) older_col[i][j] = older_q[j][i];
    end
  end

  for (genvar c = 0; c < NUM_FU; c++) begin : g_fu
    for (genvar i = 0; i < N; i++) begin : g_slot
      assign cand[c][i]  = req_i[i] & (cls_i[i] == CLS_W'(c));
      assign gnt_o[c][i] = go_i[c] & cand[c][i] & ~(|(cand[c] & older_col[i]));
    end
  end
endmodule

// File: rtl/early_wake_iq.sv
module early_wake_iq
  import ewiq_pkg::*;
#(
  parameter int unsigned DEPTH     = EWIQ_DEPTH,
  parameter int unsigned TAG_W     = EWIQ_TAG_W,
  parameter int unsigned DATA_W    = EWIQ_DATA_W,
  parameter int unsigned OP_W      = EWIQ_OP_W,
  parameter int unsigned NUM_SRC   = EWIQ_NUM_SRC,
  parameter int unsigned NUM_BCAST = EWIQ_NUM_BCAST,
  parameter int unsigned NUM_FU    = EWIQ_NUM_FU,
  parameter int unsigned CLS_W     = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      flush_i,
  input  logic                                      disp_valid_i,
  output logic                                      disp_ready_o,
  input  logic [CLS_W-1:0]                          disp_cls_i,
  input  logic [OP_W-1:0]                           disp_op_i,
  input  logic [TAG_W-1:0]                          disp_dst_i,
  input  logic [DATA_W-1:0]                         disp_lit_i,
  input  logic [NUM_SRC-1:0]                        disp_src_used_i,
  input  logic [NUM_SRC-1:0]                        disp_src_rdy_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]             disp_src_tag_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]            disp_src_val_i,
  input  logic [NUM_BCAST-1:0]                      bc_tag_vld_i,
  input  logic [NUM_BCAST-1:0][TAG_W-1:0]           bc_tag_i,
  input  logic [NUM_BCAST-1:0][DATA_W-1:0]          bc_data_i,
  input  logic [NUM_FU-1:0]                         fu_ready_i,
  output logic [NUM_FU-1:0]                         iss_valid_o,
  output logic [NUM_FU-1:0][OP_W-1:0]               iss_op_o,
  output logic [NUM_FU-1:0][TAG_W-1:0]              iss_dst_o,
  output logic [NUM_FU-1:0][DATA_W-1:0]             iss_lit_o,
  output logic [NUM_FU-1:0][NUM_SRC-1:0][DATA_W-1:0] iss_src_o
);
  logic [DEPTH-1:0]                           entry_vld, entry_req, entry_iss;
  logic [DEPTH-1:0]                           slot_free, alloc_oh, slot_wr;
  logic [DEPTH-1:0][CLS_W-1:0]                e_cls;
  logic [DEPTH-1:0][OP_W-1:0]                 e_op;
  logic [DEPTH-1:0][TAG_W-1:0]                e_dst;
  logic [DEPTH-1:0][DATA_W-1:0]               e_lit;
  logic [DEPTH-1:0][NUM_SRC-1:0][DATA_W-1:0]  e_src;
  logic [NUM_FU-1:0][DEPTH-1:0]               gnt;
  logic [NUM_FU-1:0]                          fu_go;
  logic                                       any_free, disp_fire;

  assign fu_go = flush_i ? '0 : fu_ready_i;

  always_comb begin
    entry_iss = '0;
    for (int c = 0; c < NUM_FU; c++) entry_iss |= gnt[c];
  end

  // issuing slots are reusable in the same cycle
  assign slot_free = ~entry_vld | entry_iss;

  ewiq_alloc #(.N(DEPTH)) u_alloc (
    .free_i (slot_free),
    .oh_o   (alloc_oh),
    .any_o  (any_free)
  );

  assign disp_ready_o = any_free;
  assign disp_fire    = disp_valid_i & ~flush_i & any_free;
  assign slot_wr      = disp_fire ? alloc_oh : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    ewiq_slot #(
      .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W),
      .NUM_SRC(NUM_SRC), .NUM_BCAST(NUM_BCAST), .CLS_W(CLS_W)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .wr_i       (slot_wr[i]),
      .iss_i      (entry_iss[i]),
      .cls_i      (disp_cls_i),
      .op_i       (disp_op_i),
      .dst_i      (disp_dst_i),
      .lit_i      (disp_lit_i),
      .src_used_i (disp_src_used_i),
      .src_rdy_i  (disp_src_rdy_i),
      .src_tag_i  (disp_src_tag_i),
      .src_val_i  (disp_src_val_i),
      .bc_vld_i   (bc_tag_vld_i),
      .bc_tag_i   (bc_tag_i),
      .bc_data_i  (bc_data_i),
      .vld_o      (entry_vld[i]),
      .req_o      (entry_req[i]),
      .cls_o      (e_cls[i]),
      .op_o       (e_op[i]),
      .dst_o      (e_dst[i]),
      .lit_o      (e_lit[i]),
      .src_val_o  (e_src[i])
    );
  end

  ewiq_age_sel #(.N(DEPTH), .NUM_FU(NUM_FU), .CLS_W(CLS_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (slot_wr),
    .vld_i   (entry_vld),
    .req_i   (entry_req),
    .cls_i   (e_cls),
    .go_i    (fu_go),
    .gnt_o   (gnt)
  );

  // one-hot grant mux per port
  always_comb begin
    iss_op_o  = '0;
    iss_dst_o = '0;
    iss_lit_o = '0;
    iss_src_o = '0;
    for (int c = 0; c < NUM_FU; c++) begin
      iss_valid_o[c] = |gnt[c];
      for (int i = 0; i < DEPTH; i++) begin
        if (gnt[c][i]) begin
          iss_op_o[c]  |= e_op[i];
          iss_dst_o[c] |= e_dst[i];
          iss_lit_o[c] |= e_lit[i];
          iss_src_o[c] |= e_src[i];
        end
      end
    end
  end
endmodule

// File: rtl/early_wake_iq_chk.sv
module early_wake_iq_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned NUM_FU = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          flush_i,
  input logic                          disp_valid_i,
  input logic                          disp_ready_o,
  input logic [NUM_FU-1:0]             fu_ready_i,
  input logic [NUM_FU-1:0]             iss_valid_o,
  input logic [DEPTH-1:0]              vld_i,
  input logic [NUM_FU-1:0][DEPTH-1:0]  gnt_i
);
  int   occ, nis;
  logic fire;

  assign occ  = $countones(vld_i);
  assign nis  = $countones(iss_valid_o);
  assign fire = disp_valid_i & disp_ready_o & ~flush_i;

  a_r8_issue_needs_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o & ~fu_ready_i) == '0);

  a_r10_flush_blocks_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> iss_valid_o == '0);

  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> vld_i == '0);

  a_r2_stall_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_ready_o |-> &vld_i);

  a_r9_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> occ == $past(occ) + int'($past(fire)) - $past(nis));

  for (genvar c = 0; c < NUM_FU; c++) begin : g_fu
    a_r9_single_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_i[c]));
    a_r9_pick_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_i[c] & ~vld_i) == '0);
  end
endmodule

bind early_wake_iq early_wake_iq_chk #(.DEPTH(DEPTH), .NUM_FU(NUM_FU)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .disp_valid_i (disp_valid_i),
  .disp_ready_o (disp_ready_o),
  .fu_ready_i   (fu_ready_i),
  .iss_valid_o  (iss_valid_o),
  .vld_i        (entry_vld),
  .gnt_i        (gnt)
);

// File: tb/tb_early_wake_iq.sv
`timescale 1ns/1ps
module tb_early_wake_iq;
  logic                  clk_i, rst_ni, flush_i;
  logic                  d_valid, disp_ready_o;
  logic [1:0]            d_cls;
  logic [5:0]            d_op;
  logic [4:0]            d_dst;
  logic [31:0]           d_lit;
  logic [1:0]            d_used, d_rdy;
  logic [1:0][4:0]       d_tag;
  logic [1:0][31:0]      d_val;
  logic [3:0]            bc_vld;
  logic [3:0][4:0]       bc_tag;
  logic [3:0][31:0]      bc_data;
  logic [2:0]            fu_rdy;
  logic [2:0]            iss_valid_o;
  logic [2:0][5:0]       iss_op_o;
  logic [2:0][4:0]       iss_dst_o;
  logic [2:0][31:0]      iss_lit_o;
  logic [2:0][1:0][31:0] iss_src_o;

  early_wake_iq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .disp_valid_i(d_valid), .disp_ready_o(disp_ready_o),
    .disp_cls_i(d_cls), .disp_op_i(d_op), .disp_dst_i(d_dst), .disp_lit_i(d_lit),
    .disp_src_used_i(d_used), .disp_src_rdy_i(d_rdy),
    .disp_src_tag_i(d_tag), .disp_src_val_i(d_val),
    .bc_tag_vld_i(bc_vld), .bc_tag_i(bc_tag), .bc_data_i(bc_data),
    .fu_ready_i(fu_rdy), .iss_valid_o(iss_valid_o), .iss_op_o(iss_op_o),
    .iss_dst_o(iss_dst_o), .iss_lit_o(iss_lit_o), .iss_src_o(iss_src_o)
  );

  initial clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]       cls;
    logic [5:0]       op;
    logic [4:0]       dst;
    logic [31:0]      lit;
    logic [1:0]       rdy;
    logic [1:0]       pend;
    logic [1:0][1:0]  bus;
    logic [1:0][4:0]  tag;
    logic [1:0][31:0] val;
  } ment_t;

  ment_t mq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  task automatic chk(bit ok, string ph, string what, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL [%s] %s got=%0h exp=%0h", ph, what, got, exp);
    end
  endtask

  function automatic int low_hit(logic [4:0] t);
    for (int k = 0; k < 4; k++) if (bc_vld[k] && bc_tag[k] == t) return k;
    return -1;
  endfunction

  task automatic eval(string ph);
    bit    gone[16];
    int    pick[3];
    int    nis = 0;
    int    b;
    bit    exp_dr;
    ment_t e;
    ment_t nq[$];
    logic [31:0] ev;
    for (int i = 0; i < 16; i++) gone[i] = 0;
    for (int c = 0; c < 3; c++) begin
      pick[c] = -1;
      if (!flush_i && fu_rdy[c]) begin
        for (int i = 0; i < mq.size(); i++) begin
          if (!gone[i] && mq[i].cls == 2'(c) && (&mq[i].rdy)) begin
            pick[c] = i; gone[i] = 1; nis++;
            break;
          end
        end
      end
    end
    exp_dr = (mq.size() - nis) < 16;
    chk(disp_ready_o === exp_dr, ph, "R2 disp_ready", 64'(disp_ready_o), 64'(exp_dr));
    for (int c = 0; c < 3; c++) begin
      chk(iss_valid_o[c] === (pick[c] >= 0), ph, "R8/R9 iss_valid",
          64'(iss_valid_o[c]), 64'(pick[c] >= 0));
      if (pick[c] >= 0 && iss_valid_o[c]) begin
        e = mq[pick[c]];
        chk(iss_op_o[c]  === e.op,  ph, "R11 iss_op",  64'(iss_op_o[c]),  64'(e.op));
        chk(iss_dst_o[c] === e.dst, ph, "R11 iss_dst", 64'(iss_dst_o[c]), 64'(e.dst));
        chk(iss_lit_o[c] === e.lit, ph, "R11 iss_lit", 64'(iss_lit_o[c]), 64'(e.lit));
        for (int s = 0; s < 2; s++) begin
          ev = e.pend[s] ? bc_data[e.bus[s]] : e.val[s];
          chk(iss_src_o[c][s] === ev, ph, "R4/R5/R7 iss_src", 64'(iss_src_o[c][s]), 64'(ev));
        end
      end
    end
    // next-state of the model
    for (int i = 0; i < mq.size(); i++) begin
      if (!gone[i]) begin
        e = mq[i];
        for (int s = 0; s < 2; s++) begin
          if (e.pend[s]) begin
            e.val[s] = bc_data[e.bus[s]]; e.pend[s] = 1'b0;
          end else if (!e.rdy[s]) begin
            b = low_hit(e.tag[s]);
            if (b >= 0) begin e.rdy[s] = 1'b1; e.pend[s] = 1'b1; e.bus[s] = 2'(b); end
          end
        end
        nq.push_back(e);
      end
    end
    if (!flush_i && d_valid && exp_dr) begin
      e = '0;
      e.cls = d_cls; e.op = d_op; e.dst = d_dst; e.lit = d_lit; e.tag = d_tag; e.val = d_val;
      for (int s = 0; s < 2; s++) begin
        if (!d_used[s] || d_rdy[s]) e.rdy[s] = 1'b1;
        else begin
          b = low_hit(d_tag[s]);
          if (b >= 0) begin e.rdy[s] = 1'b1; e.pend[s] = 1'b1; e.bus[s] = 2'(b); end
        end
      end
      nq.push_back(e);
    end
    if (flush_i) nq.delete();
    mq = nq;
  endtask

  task automatic run(string ph);
    #1;
    eval(ph);
    @(negedge clk_i);
  endtask

  task automatic idle();
    flush_i = 0; d_valid = 0; d_cls = 0; d_op = 0; d_dst = 0; d_lit = 0;
    d_used = 0; d_rdy = 0; d_tag = '0; d_val = '0;
    bc_vld = 0; bc_tag = '0; fu_rdy = 0;
    for (int k = 0; k < 4; k++) bc_data[k] = $urandom;
  endtask

  task automatic set_disp(int cls, int op, logic [1:0] used, logic [1:0] rdy,
                          logic [4:0] t1, logic [4:0] t0, logic [31:0] v1, logic [31:0] v0);
    d_valid = 1; d_cls = 2'(cls); d_op = 6'(op); d_dst = 5'(op + 8);
    d_lit = 32'h1000 + 32'(op); d_used = used; d_rdy = rdy;
    d_tag = {t1, t0}; d_val = {v1, v0};
  endtask

  task automatic set_bc(int k, logic [4:0] t);
    bc_vld[k] = 1'b1; bc_tag[k] = t;
  endtask

  initial begin
    rst_ni = 0;
    idle();
    repeat (3) @(negedge clk_i);
    #1;
    chk(iss_valid_o === 3'b000, "R1", "R1 iss_valid in reset", 64'(iss_valid_o), 64'h0);
    chk(disp_ready_o === 1'b1, "R1", "R1 disp_ready in reset", 64'(disp_ready_o), 64'h1);
    @(negedge clk_i);
    rst_ni = 1;
    idle(); fu_rdy = 3'b111; run("R1");
    idle(); fu_rdy = 3'b111; run("R1");

    // back-to-back wakeup and retained value
    idle(); set_disp(0, 1, 2'b01, 2'b00, 5'd0, 5'd9, 32'h0, 32'h0); run("R4");
    idle(); set_disp(1, 2, 2'b11, 2'b10, 5'd3, 5'd10, 32'h22, 32'h0);
    set_bc(2, 5'd9); set_bc(0, 5'd10); fu_rdy = 3'b001; run("R4");
    idle(); bc_data[2] = 32'hABCD; bc_data[0] = 32'h5555; fu_rdy = 3'b001; run("R4");
    idle(); run("R5");
    idle(); fu_rdy = 3'b010; run("R5");

    // wake in the dispatch cycle
    idle(); set_disp(2, 3, 2'b01, 2'b00, 5'd0, 5'd12, 32'h0, 32'h0); set_bc(3, 5'd12); run("R6");
    idle(); bc_data[3] = 32'hD00D; fu_rdy = 3'b100; run("R6");

    // same tag on two buses
    idle(); set_disp(0, 4, 2'b11, 2'b00, 5'd14, 5'd13, 32'h0, 32'h0); run("R7");
    idle(); set_bc(1, 5'd13); set_bc(3, 5'd13); set_bc(0, 5'd14); run("R7");
    idle(); bc_data[1] = 32'h1111; bc_data[3] = 32'h3333; bc_data[0] = 32'h0F0F; fu_rdy = 3'b001; run("R7");

    // ready at dispatch, unused sources
    idle(); set_disp(1, 5, 2'b10, 2'b10, 5'd7, 5'd7, 32'hBEEF, 32'hCAFE); set_bc(0, 5'd7); run("R3");
    idle(); fu_rdy = 3'b010; run("R3");

    // fill, stall, reuse an issuing slot
    for (int i = 0; i < 17; i++) begin
      idle(); set_disp(i % 3, 20 + i, 2'b11, 2'b11, 5'd1, 5'd2, 32'(i), 32'(i * 7)); run("R2");
    end
    idle(); set_disp(0, 50, 2'b00, 2'b00, 5'd0, 5'd0, 32'h0, 32'h0); fu_rdy = 3'b001; run("R2");
    for (int i = 0; i < 8; i++) begin idle(); fu_rdy = 3'b011; run("R8"); end
    for (int i = 0; i < 12; i++) begin idle(); fu_rdy = 3'b111; run("R8/R9"); end

    // flush
    for (int i = 0; i < 3; i++) begin
      idle(); set_disp(i, 60 + i, 2'b01, 2'b00, 5'd0, 5'd20, 32'h0, 32'h0); run("R10");
    end
    idle(); flush_i = 1; fu_rdy = 3'b111; set_bc(0, 5'd20);
    set_disp(0, 63, 2'b00, 2'b00, 5'd0, 5'd0, 32'h0, 32'h0); run("R10");
    idle(); fu_rdy = 3'b111; run("R10");
    idle(); fu_rdy = 3'b111; run("R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      flush_i = ($urandom_range(99, 0) == 0);
      for (int c = 0; c < 3; c++) fu_rdy[c] = ($urandom_range(9, 0) < 6);
      for (int k = 0; k < 4; k++)
        if ($urandom_range(9, 0) < 4) set_bc(k, 5'($urandom_range(15, 0)));
      if ($urandom_range(9, 0) < 7)
        set_disp($urandom_range(2, 0), $urandom_range(63, 0), 2'($urandom_range(3, 0)),
                 2'($urandom_range(3, 0)), 5'($urandom_range(15, 0)), 5'($urandom_range(15, 0)),
                 $urandom, $urandom);
      run("R3/R9/R11");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R9 run did not complete: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule